// File: doc/BRIEF.md
# Accumulator Register-Operation Executor

This block carries out the register-class operations of a small accumulator machine. It owns a 16-bit accumulator and a 1-bit extension flag. The control sequencer raises a single-cycle strobe in the execute slot of a register-class instruction and presents the low 12 bits of that instruction as an operation field in which each bit selects one operation.

On the clock edge that samples the strobe, the block updates the accumulator and flag. In the same edge it registers three one-cycle pulses:

- a done pulse, which returns the sequencer to fetch;
- a skip pulse, which asks the program counter to advance once more;
- a halt pulse, which clears the machine's run flag.

Rotations treat the accumulator and flag as one 17-bit ring. Skip tests look at the accumulator sign bit, the all-zero state of the accumulator, and the flag.

Top module: `accum_regop_exec`

## Requirements
- R1: Field bit 11 clears the accumulator. Field bit 10 clears the flag E.
- R2: Field bit 9 inverts every accumulator bit. Field bit 8 inverts E.
- R3: Field bit 5 adds one to the accumulator. 0xFFFF wraps to 0x0000, and E is left unchanged.
- R4: Field bit 7 rotates right. The new accumulator is {old E, old AC[15:1]} and the new E is old AC[0].
- R5: Field bit 6 rotates left. The new accumulator is {old AC[14:0], old E} and the new E is old AC[15].
- R6: Field bit 4 skips when AC[15] is 0. Field bit 3 skips when AC[15] is 1.
- R7: Field bit 2 skips when all 16 accumulator bits are 0. Field bit 1 skips when E is 0. A skip is a skip_pulse high for exactly one cycle; a condition that is not met gives no pulse.
- R8: Every sampled strobe produces done_pulse high in the following cycle only. This includes an all-zero field, which changes nothing.
- R9: Field bit 0 produces halt_pulse high for one cycle, together with done_pulse. The accumulator and E stay as they were.
- R10: When several field bits are set, only the highest-numbered one takes effect.
- R11: While exec_en is low, the accumulator and E hold their values and no pulse is produced.
- R12: Reset (rst_n low) clears the accumulator and E to 0 and holds all pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | Execute strobe for a register-class instruction |
| op_field | input | 12 | Operation field, one bit per operation |
| ac_q | output | 16 | Accumulator |
| e_q | output | 1 | Extension flag E |
| skip_pulse | output | 1 | Request to advance the program counter once |
| halt_pulse | output | 1 | Request to clear the run flag |
| done_pulse | output | 1 | Request to clear the sequencer |

## Verification
On every cycle the assertions check the following:

- the hold-and-silence rule while the strobe is low;
- the done pulse that follows each strobe;
- skip being issued only together with done;
- for isolated single-bit fields, the exact increment, rotate, zero-skip and halt results against the previous cycle's state.

The bench's vector sequence covers the remaining behaviour:

- the priority among combined field bits;
- the wrap of the increment at 0xFFFF;
- skip conditions evaluated on accumulator values that earlier rotations and complements built up;
- a reset applied in the middle of a run.

// File: rtl/regop_pkg.sv
package regop_pkg;

    localparam int ACC_WIDTH = 16;
    localparam int FIELD_WIDTH = 12;

    // Bit positions within the operation field (priority: higher index wins)
    localparam int OP_CLR_AC  = 11;
    localparam int OP_CLR_E   = 10;
    localparam int OP_INV_AC  = 9;
    localparam int OP_INV_E   = 8;
    localparam int OP_ROT_R   = 7;
    localparam int OP_ROT_L   = 6;
    localparam int OP_INC_AC  = 5;
    localparam int OP_SK_POS  = 4;
    localparam int OP_SK_NEG  = 3;
    localparam int OP_SK_ZAC  = 2;
    localparam int OP_SK_ZE   = 1;
    localparam int OP_HALT    = 0;

endpackage

// File: rtl/regop_prio_sel.sv
module regop_prio_sel #(
    parameter int W = regop_pkg::FIELD_WIDTH
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant
);
    // Keep only the highest-numbered set bit (R10)
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == W - 1) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[W-1:i+1]);
        end
    end
endmodule

// File: rtl/regop_datapath.sv
module regop_datapath
    import regop_pkg::*;
#(
    parameter int AC_W = ACC_WIDTH,
    parameter int OP_W = FIELD_WIDTH
) (
    input  logic [AC_W-1:0] ac_cur,
    input  logic            e_cur,
    input  logic [OP_W-1:0] grant,
    output logic [AC_W-1:0] ac_nxt,
    output logic            e_nxt
);
    always_comb begin
        ac_nxt = ac_cur;
        e_nxt  = e_cur;
        if (grant[OP_CLR_AC]) begin
            ac_nxt = '0;
        end
        if (grant[OP_CLR_E]) begin
            e_nxt = 1'b0;
        end
        if (grant[OP_INV_AC]) begin
            ac_nxt = ~ac_cur;
        end
        if (grant[OP_INV_E]) begin
            e_nxt = ~e_cur;
        end
        if (grant[OP_ROT_R]) begin
            ac_nxt = {e_cur, ac_cur[AC_W-1:1]};
            e_nxt  = ac_cur[0];
        end
        if (grant[OP_ROT_L]) begin
            ac_nxt = {ac_cur[AC_W-2:0], e_cur};
            e_nxt  = ac_cur[AC_W-1];
        end
        if (grant[OP_INC_AC]) begin
            ac_nxt = ac_cur + AC_W'(1);
        end
    end
endmodule

// File: rtl/regop_skip_eval.sv
module regop_skip_eval
    import regop_pkg::*;
#(
    parameter int AC_W = ACC_WIDTH,
    parameter int OP_W = FIELD_WIDTH
) (
    input  logic [AC_W-1:0] ac_cur,
    input  logic            e_cur,
    input  logic [OP_W-1:0] grant,
    output logic            skip_hit
);
    logic sign_bit;
    logic ac_zero;

    always_comb begin
        sign_bit = ac_cur[AC_W-1];
        ac_zero  = (ac_cur == '0);
        skip_hit = (grant[OP_SK_POS] & ~sign_bit)
                 | (grant[OP_SK_NEG] &  sign_bit)
                 | (grant[OP_SK_ZAC] &  ac_zero)
                 | (grant[OP_SK_ZE]  & ~e_cur);
    end
endmodule

// File: rtl/accum_regop_exec.sv
module accum_regop_exec
    import regop_pkg::*;
#(
    parameter int AC_W = ACC_WIDTH,
    parameter int OP_W = FIELD_WIDTH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec_en,
    input  logic [OP_W-1:0] op_field,
    output logic [AC_W-1:0] ac_q,
    output logic            e_q,
    output logic            skip_pulse,
    output logic            halt_pulse,
    output logic            done_pulse
);
    typedef struct packed {
        logic [AC_W-1:0] ac;
        logic            e;
        logic            skip;
        logic            halt;
        logic            done;
    } exec_state_t;

    exec_state_t st_d, st_q;
    logic [OP_W-1:0] grant;
    logic [AC_W-1:0] ac_nxt;
    logic            e_nxt;
    logic            skip_hit;

    regop_prio_sel #(.W(OP_W)) u_sel (
        .req   (op_field),
        .grant (grant)
    );

    regop_datapath #(.AC_W(AC_W), .OP_W(OP_W)) u_dp (
        .ac_cur (st_q.ac),
        .e_cur  (st_q.e),
        .grant  (grant),
        .ac_nxt (ac_nxt),
        .e_nxt  (e_nxt)
    );

    regop_skip_eval #(.AC_W(AC_W), .OP_W(OP_W)) u_skip (
        .ac_cur   (st_q.ac),
        .e_cur    (st_q.e),
        .grant    (grant),
        .skip_hit (skip_hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.skip = 1'b0;
        st_d.halt = 1'b0;
        st_d.done = 1'b0;
        if (exec_en) begin
            st_d.ac   = ac_nxt;
            st_d.e    = e_nxt;
            st_d.skip = skip_hit;
            st_d.halt = grant[OP_HALT];
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ac_q       = st_q.ac;
    assign e_q        = st_q.e;
    assign skip_pulse = st_q.skip;
    assign halt_pulse = st_q.halt;
    assign done_pulse = st_q.done;
endmodule

// File: rtl/regop_exec_chk.sv
module regop_exec_chk
    import regop_pkg::*;
#(
    parameter int AC_W = ACC_WIDTH,
    parameter int OP_W = FIELD_WIDTH
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exec_en,
    input logic [OP_W-1:0] op_field,
    input logic [AC_W-1:0] ac_q,
    input logic            e_q,
    input logic            skip_pulse,
    input logic            halt_pulse,
    input logic            done_pulse
);
    localparam logic [OP_W-1:0] F_INC  = OP_W'(1) << OP_INC_AC;
    localparam logic [OP_W-1:0] F_ROTR = OP_W'(1) << OP_ROT_R;
    localparam logic [OP_W-1:0] F_ROTL = OP_W'(1) << OP_ROT_L;
    localparam logic [OP_W-1:0] F_SZA  = OP_W'(1) << OP_SK_ZAC;
    localparam logic [OP_W-1:0] F_HALT = OP_W'(1) << OP_HALT;

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> ($stable(ac_q) && $stable(e_q) && !done_pulse && !skip_pulse && !halt_pulse));

    a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> done_pulse);

    a_r7_skip_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        skip_pulse |-> done_pulse);

    a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_field == F_INC) |=>
            (ac_q == $past(ac_q) + AC_W'(1)) && (e_q == $past(e_q)));

    a_r4_rotate_right: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_field == F_ROTR) |=>
            (ac_q == {$past(e_q), $past(ac_q[AC_W-1:1])}) && (e_q == $past(ac_q[0])));

    a_r5_rotate_left: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_field == F_ROTL) |=>
            (ac_q == {$past(ac_q[AC_W-2:0]), $past(e_q)}) && (e_q == $past(ac_q[AC_W-1])));

    a_r7_zero_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_field == F_SZA) |=> (skip_pulse == ($past(ac_q) == '0)));

    a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_field == F_HALT) |=> (halt_pulse && $stable(ac_q) && $stable(e_q)));
endmodule

bind accum_regop_exec regop_exec_chk #(.AC_W(AC_W), .OP_W(OP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_en    (exec_en),
    .op_field   (op_field),
    .ac_q       (ac_q),
    .e_q        (e_q),
    .skip_pulse (skip_pulse),
    .halt_pulse (halt_pulse),
    .done_pulse (done_pulse)
);

// File: tb/tb_accum_regop_exec.sv
module tb_accum_regop_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic [11:0] op_field = '0;
    logic [15:0] ac_q;
    logic        e_q, skip_pulse, halt_pulse, done_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    accum_regop_exec dut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_field(op_field),
        .ac_q(ac_q), .e_q(e_q), .skip_pulse(skip_pulse),
        .halt_pulse(halt_pulse), .done_pulse(done_pulse)
    );

    // {field, expected AC, expected E, expected skip, expected halt}
    // Walked in order from the reset state AC=0, E=0.
    localparam int NV = 27;
    localparam logic [30:0] VEC [NV] = '{
        {12'h400, 16'h0000, 1'b0, 1'b0, 1'b0},  // R1 clear E
        {12'h100, 16'h0000, 1'b1, 1'b0, 1'b0},  // R2 invert E
        {12'h040, 16'h0001, 1'b0, 1'b0, 1'b0},  // R5 rotate left
        {12'h040, 16'h0002, 1'b0, 1'b0, 1'b0},  // R5
        {12'h080, 16'h0001, 1'b0, 1'b0, 1'b0},  // R4 rotate right
        {12'h080, 16'h0000, 1'b1, 1'b0, 1'b0},  // R4
        {12'h080, 16'h8000, 1'b0, 1'b0, 1'b0},  // R4
        {12'h008, 16'h8000, 1'b0, 1'b1, 1'b0},  // R6 negative taken
        {12'h010, 16'h8000, 1'b0, 1'b0, 1'b0},  // R6 positive not taken
        {12'h002, 16'h8000, 1'b0, 1'b1, 1'b0},  // R7 E zero taken
        {12'h004, 16'h8000, 1'b0, 1'b0, 1'b0},  // R7 AC zero not taken
        {12'h200, 16'h7FFF, 1'b0, 1'b0, 1'b0},  // R2 invert AC
        {12'h010, 16'h7FFF, 1'b0, 1'b1, 1'b0},  // R6 positive taken
        {12'h020, 16'h8000, 1'b0, 1'b0, 1'b0},  // R3 increment
        {12'h040, 16'h0000, 1'b1, 1'b0, 1'b0},  // R5
        {12'h004, 16'h0000, 1'b1, 1'b1, 1'b0},  // R7 AC zero taken
        {12'h002, 16'h0000, 1'b1, 1'b0, 1'b0},  // R7 E zero not taken
        {12'h200, 16'hFFFF, 1'b1, 1'b0, 1'b0},  // R2
        {12'h020, 16'h0000, 1'b1, 1'b0, 1'b0},  // R3 wrap, E kept
        {12'h008, 16'h0000, 1'b1, 1'b0, 1'b0},  // R6 negative not taken
        {12'h001, 16'h0000, 1'b1, 1'b0, 1'b1},  // R9 halt
        {12'h000, 16'h0000, 1'b1, 1'b0, 1'b0},  // R8 empty field
        {12'hC00, 16'h0000, 1'b1, 1'b0, 1'b0},  // R10 clear AC beats clear E
        {12'h300, 16'hFFFF, 1'b1, 1'b0, 1'b0},  // R10 invert AC beats invert E
        {12'h021, 16'h0000, 1'b1, 1'b0, 1'b0},  // R10 increment beats halt
        {12'h104, 16'h0000, 1'b0, 1'b0, 1'b0},  // R10 invert E beats AC-zero skip
        {12'h801, 16'h0000, 1'b0, 1'b0, 1'b0}   // R10 clear AC beats halt
    };

    function automatic string tag_of(input logic [11:0] f);
        if (f == 12'h000) return "R8";
        if ($countones(f) > 1) return "R10";
        case (f)
            12'h800, 12'h400: return "R1";
            12'h200, 12'h100: return "R2";
            12'h020:          return "R3";
            12'h080:          return "R4";
            12'h040:          return "R5";
            12'h010, 12'h008: return "R6";
            12'h004, 12'h002: return "R7";
            default:          return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic fire(input logic [11:0] f);
        @(negedge clk);
        exec_en  = 1'b1;
        op_field = f;
        @(negedge clk);
        exec_en  = 1'b0;
        op_field = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "ac", 32'(ac_q), 32'h0);
        check("R12", "pulses", {29'b0, skip_pulse, halt_pulse, done_pulse}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "e", 32'(e_q), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [11:0] f;
            string t;
            f = VEC[i][30:19];
            t = tag_of(f);
            fire(f);
            check(t, "ac", 32'(ac_q), 32'(VEC[i][18:3]));
            check(t, "e", 32'(e_q), 32'(VEC[i][2]));
            check(t, "skip", 32'(skip_pulse), 32'(VEC[i][1]));
            check(t, "halt", 32'(halt_pulse), 32'(VEC[i][0]));
            check("R8", "done", 32'(done_pulse), 32'h1);
        end

        // R8 done lasts one cycle; R11 idle holds state and stays silent
        fire(12'h100);  // E -> 1
        check("R2", "e", 32'(e_q), 32'h1);
        fire(12'h200);  // AC -> FFFF
        @(negedge clk);
        check("R8", "done low after one cycle", 32'(done_pulse), 32'h0);
        op_field = 12'hFFF;  // strobe low: field must be ignored
        repeat (4) begin
            @(negedge clk);
            check("R11", "ac hold", 32'(ac_q), 32'hFFFF);
            check("R11", "e hold", 32'(e_q), 32'h1);
            check("R11", "pulses", {29'b0, skip_pulse, halt_pulse, done_pulse}, 32'h0);
        end
        op_field = '0;

        // R6 negative skip on FFFF, and R7 skip on E=1 not taken
        fire(12'h008);
        check("R6", "skip", 32'(skip_pulse), 32'h1);
        fire(12'h002);
        check("R7", "skip", 32'(skip_pulse), 32'h0);
        @(negedge clk);
        check("R7", "skip one cycle", 32'(skip_pulse), 32'h0);

        // R12 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R12", "ac after reset", 32'(ac_q), 32'h0);
        check("R12", "e after reset", 32'(e_q), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule